// File: doc/BRIEF.md
# Carry-Aware 16-bit ALU

This block is the arithmetic and logic unit of a small 16-bit RISC core with eight general registers. The register file supplies two 16-bit operands. Instruction decode supplies a 5-bit operation class, a 2-bit function field, a 5-bit immediate and an immediate-select bit. The result, the zero output and the carry output are combinational. Branch logic can use zero and carry in the same cycle.

The block keeps one piece of state, the carry flag. It resets to 0. When the flag-write enable is high, the flag is committed on the rising clock edge. Add-with-carry and subtract-with-borrow read the flag. Set-carry forces it to 1. Logical, shift and unassigned classes never change it.

The function field tells apart the variants that share an operation class, and the ALU decodes it directly. Operation class codes: 0 is arithmetic, 1 is bitwise, 2 is shift/move, 4 is set-carry. Every other class is unassigned.

Top module: `alu16_carry`

## Requirements
- R1: Class 0, function 00 (plain add) gives result = (A + B) mod 2^16 and carry_out = bit 16 of the sum. The stored carry flag has no effect.
- R2: Class 0, function 01 (add with carry) gives result = (A + B + carry_q) mod 2^16, and carry_out is the carry out of bit 15.
- R3: Class 0, function 10 (plain subtract) gives result = (A - B) mod 2^16 and carry_out = 1 exactly when A < B (a borrow). The stored flag has no effect.
- R4: Class 0, function 11 (subtract with borrow) gives result = (A - B - carry_q) mod 2^16 and carry_out = 1 exactly when A < B + carry_q.
- R5: Class 1 is bitwise. Function 00 is A AND B, 01 is A OR B, 10 is A XOR B, and 11 is NOT A (B is ignored).
- R6: Class 2 shifts. Function 00 shifts A left by one place and function 01 shifts A right by one place. The vacated bit is filled with 0 and the bit shifted out is lost. Functions 10 and 11 pass A through unchanged.
- R7: When imm_sel is 1, the second operand is the 5-bit immediate zero-extended to 16 bits (0 to 31) in place of B. This is how immediate add and immediate subtract are formed.
- R8: carry_q is 0 after a clock edge with rst_n low. On a clock edge with flag_we high, carry_q takes the carry_out value of that cycle. For class 4 (set-carry), carry_out is 1.
- R9: Logical, shift and unassigned classes drive carry_out equal to carry_q, so carry_q keeps its value even when flag_we is high. With flag_we low, carry_q holds for any operation.
- R10: zero is 1 exactly when result is 0. Unassigned classes, and class 4, give result 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the carry flag |
| rst_n | input | 1 | Synchronous active-low reset |
| op_class | input | 5 | Operation class code |
| func | input | 2 | Variant within the class |
| imm5 | input | 5 | Unsigned immediate |
| imm_sel | input | 1 | Use the zero-extended immediate as the second operand |
| src_a | input | 16 | First operand |
| src_b | input | 16 | Second operand |
| flag_we | input | 1 | Commit carry_out into the carry flag at the clock edge |
| result | output | 16 | Operation result |
| zero | output | 1 | Result equals zero |
| carry_out | output | 1 | Carry or borrow of this operation (flag value for non-arithmetic) |
| carry_q | output | 1 | Stored carry flag |

## Verification
The hardest cases are the ones where a stored flag changes the outcome of an arithmetic step. Examples are add-with-carry of 0xFFFF + 0 with the flag set, and subtract-with-borrow of equal operands. Both depend on an earlier cycle having committed the right flag. The stimulus reaches these cases in two ways. It uses set-carry or an overflowing add with flag_we high, then issues the carry-consuming operation on the next cycle. It also tries to disturb the flag through logical operations with flag_we high. A long run of random operations, each with a random flag write, then compares every cycle against the behavioural model.

// File: rtl/alu16_pkg.sv
// Package: shared widths and encodings for the carry-aware ALU.
// Assumes a 5-bit class code and a 2-bit function field from decode.
package alu16_pkg;
    localparam int CLS_W  = 5;
    localparam int FUNC_W = 2;

    typedef enum logic [CLS_W-1:0] {
        CLS_ARITH = 5'd0,
        CLS_LOGIC = 5'd1,
        CLS_SHIFT = 5'd2,
        CLS_SETC  = 5'd4
    } alu_class_e;

    localparam logic [FUNC_W-1:0] F_ARITH_ADD = 2'b00;
    localparam logic [FUNC_W-1:0] F_ARITH_ADC = 2'b01;
    localparam logic [FUNC_W-1:0] F_ARITH_SUB = 2'b10;
    localparam logic [FUNC_W-1:0] F_ARITH_SBB = 2'b11;

    localparam logic [FUNC_W-1:0] F_LOG_AND = 2'b00;
    localparam logic [FUNC_W-1:0] F_LOG_OR  = 2'b01;
    localparam logic [FUNC_W-1:0] F_LOG_XOR = 2'b10;
    localparam logic [FUNC_W-1:0] F_LOG_NOT = 2'b11;

    localparam logic [FUNC_W-1:0] F_SH_LEFT  = 2'b00;
    localparam logic [FUNC_W-1:0] F_SH_RIGHT = 2'b01;
endpackage

// File: rtl/alu16_addsub.sv
// Adder/subtractor: one (W+1)-bit sum serves both add and subtract.
// Subtract inverts B and inverts the carry-in sense. carry_o reports a
// carry for add and a borrow for subtract.
// Assumes B is already muxed (register or immediate).
module alu16_addsub #(
    parameter int W = 16
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sub_i,
    input  logic         use_flag_i,
    input  logic         flag_i,
    output logic [W-1:0] sum_o,
    output logic         carry_o
);
    logic [W-1:0] b_x;
    logic         cin;
    logic [W:0]   wide;

    // Operand conditioning: invert B and pick the carry-in for the mode.
    always_comb begin
        b_x = sub_i ? ~b_i : b_i;
        if (sub_i) cin = use_flag_i ? ~flag_i : 1'b1;
        else       cin = use_flag_i ?  flag_i : 1'b0;
    end

    // Single wide addition; top bit is carry (add) or not-borrow (sub).
    always_comb begin
        wide    = {1'b0, a_i} + {1'b0, b_x} + {{W{1'b0}}, cin};
        sum_o   = wide[W-1:0];
        carry_o = sub_i ? ~wide[W] : wide[W];
    end
endmodule

// File: rtl/alu16_logic.sv
// Bitwise unit: AND, OR, XOR of both operands, or NOT of A.
// One generated cell per bit, with the function decoded in each cell.
module alu16_logic #(
    parameter int W = 16
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [1:0]   func_i,
    output logic [W-1:0] y_o
);
    import alu16_pkg::*;

    for (genvar i = 0; i < W; i++) begin : g_bit
        // Per-bit function select.
        always_comb begin
            unique case (func_i)
                F_LOG_AND: y_o[i] = a_i[i] & b_i[i];
                F_LOG_OR:  y_o[i] = a_i[i] | b_i[i];
                F_LOG_XOR: y_o[i] = a_i[i] ^ b_i[i];
                default:   y_o[i] = ~a_i[i];
            endcase
        end
    end
endmodule

// File: rtl/alu16_shift.sv
// Single-place shifter with zero fill; the bit shifted out is dropped.
// Functions other than left and right pass A through (move).
module alu16_shift #(
    parameter int W = 16
) (
    input  logic [W-1:0] a_i,
    input  logic [1:0]   func_i,
    output logic [W-1:0] y_o
);
    import alu16_pkg::*;

    // Direction select.
    always_comb begin
        unique case (func_i)
            F_SH_LEFT:  y_o = {a_i[W-2:0], 1'b0};
            F_SH_RIGHT: y_o = {1'b0, a_i[W-1:1]};
            default:    y_o = a_i;
        endcase
    end
endmodule

// File: rtl/alu16_flag.sv
// Carry flag register with synchronous active-low reset and write enable.
// Assumes the next value is already chosen by the top-level mux.
module alu16_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic we_i,
    input  logic d_i,
    output logic q_o
);
    // Commit the new flag on an enabled edge; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)    q_o <= 1'b0;
        else if (we_i) q_o <= d_i;
    end
endmodule

// File: rtl/alu16_carry.sv
// Top: carry-aware 16-bit ALU. The datapath is combinational and the carry
// flag is registered. Assumes decode provides class, function, immediate and
// the immediate select in the same cycle as the operands.
module alu16_carry #(
    parameter int W     = 16,
    parameter int IMM_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [4:0]       op_class,
    input  logic [1:0]       func,
    input  logic [IMM_W-1:0] imm5,
    input  logic             imm_sel,
    input  logic [W-1:0]     src_a,
    input  logic [W-1:0]     src_b,
    input  logic             flag_we,
    output logic [W-1:0]     result,
    output logic             zero,
    output logic             carry_out,
    output logic             carry_q
);
    import alu16_pkg::*;

    localparam int PAD_W = W - IMM_W;

    logic [W-1:0] opnd_b;
    logic [W-1:0] as_sum, lg_y, sh_y;
    logic         as_carry;
    logic         as_sub, as_use_flag;

    // Second-operand select: zero-extended immediate or register.
    always_comb opnd_b = imm_sel ? {{PAD_W{1'b0}}, imm5} : src_b;

    // Arithmetic mode bits are taken straight from the function field.
    always_comb begin
        as_sub      = func[1];
        as_use_flag = func[0];
    end

    alu16_addsub #(.W(W)) u_addsub (
        .a_i(src_a), .b_i(opnd_b), .sub_i(as_sub), .use_flag_i(as_use_flag),
        .flag_i(carry_q), .sum_o(as_sum), .carry_o(as_carry)
    );

    alu16_logic #(.W(W)) u_logic (
        .a_i(src_a), .b_i(opnd_b), .func_i(func), .y_o(lg_y)
    );

    alu16_shift #(.W(W)) u_shift (
        .a_i(src_a), .func_i(func), .y_o(sh_y)
    );

    // Result and carry selection by operation class.
    always_comb begin
        result    = '0;
        carry_out = carry_q;
        case (op_class)
            CLS_ARITH: begin result = as_sum; carry_out = as_carry; end
            CLS_LOGIC: result = lg_y;
            CLS_SHIFT: result = sh_y;
            CLS_SETC:  carry_out = 1'b1;
            default:   result = '0;
        endcase
    end

    // Zero detect for branch logic.
    always_comb zero = (result == '0);

    alu16_flag u_flag (
        .clk(clk), .rst_n(rst_n), .we_i(flag_we), .d_i(carry_out), .q_o(carry_q)
    );
endmodule

// File: rtl/alu16_carry_chk.sv
// Checker for alu16_carry, attached by bind. Relates ports across cycles.
module alu16_carry_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [4:0]  op_class,
    input logic [1:0]  func,
    input logic        imm_sel,
    input logic [15:0] src_a,
    input logic [15:0] src_b,
    input logic        flag_we,
    input logic [15:0] result,
    input logic        carry_out,
    input logic        carry_q
);
    AST_FLAG_CLEAR: assert property (@(posedge clk) !rst_n |=> !carry_q); // R8
    AST_FLAG_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we |=> carry_q == $past(carry_out)); // R8
    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_we |=> $stable(carry_q)); // R9
    AST_LOGIC_KEEPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (op_class == 5'd1 || op_class == 5'd2) |-> carry_out == carry_q); // R9
    AST_ADD_ZERO_B: assert property (@(posedge clk) disable iff (!rst_n)
        (op_class == 5'd0 && func == 2'b00 && !imm_sel && src_b == 16'd0)
        |-> (result == src_a && !carry_out)); // R1
    AST_SHL_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (op_class == 5'd2 && func == 2'b00) |-> result[0] == 1'b0); // R6
    AST_UNUSED_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        (op_class > 5'd2 && op_class != 5'd4) |-> result == 16'd0); // R10
endmodule

bind alu16_carry alu16_carry_chk u_chk (
    .clk(clk), .rst_n(rst_n), .op_class(op_class), .func(func),
    .imm_sel(imm_sel), .src_a(src_a), .src_b(src_b), .flag_we(flag_we),
    .result(result), .carry_out(carry_out), .carry_q(carry_q)
);

// File: tb/tb_alu16_carry.sv
module tb_alu16_carry;
    localparam time TCK = 20ns;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [4:0]  op_class;
    logic [1:0]  func;
    logic [4:0]  imm5;
    logic        imm_sel;
    logic [15:0] src_a, src_b;
    logic        flag_we;
    logic [15:0] result;
    logic        zero, carry_out, carry_q;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    bit m_flag = 1'b0;   // model of the carry flag

    always #(TCK/2) clk = ~clk;

    alu16_carry dut (
        .clk(clk), .rst_n(rst_n), .op_class(op_class), .func(func),
        .imm5(imm5), .imm_sel(imm_sel), .src_a(src_a), .src_b(src_b),
        .flag_we(flag_we), .result(result), .zero(zero),
        .carry_out(carry_out), .carry_q(carry_q)
    );

    task automatic cmp(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Behavioural model: returns expected result and carry for current inputs.
    task automatic model(output int res, output bit cy);
        int a, b, d;
        a = int'(src_a);
        b = imm_sel ? int'(imm5) : int'(src_b);
        res = 0; cy = m_flag;
        case (op_class)
            5'd0: begin
                case (func)
                    2'd0: d = a + b;
                    2'd1: d = a + b + int'(m_flag);
                    2'd2: d = a - b;
                    default: d = a - b - int'(m_flag);
                endcase
                if (func[1]) cy = (d < 0); else cy = (d > 65535);
                res = d & 16'hFFFF;
            end
            5'd1: case (func)
                2'd0: res = a & b;
                2'd1: res = a | b;
                2'd2: res = a ^ b;
                default: res = (~a) & 16'hFFFF;
            endcase
            5'd2: case (func)
                2'd0: res = (a * 2) & 16'hFFFF;
                2'd1: res = a / 2;
                default: res = a;
            endcase
            5'd4: cy = 1'b1;
            default: res = 0;
        endcase
    endtask

    // Apply one operation: drive after the edge, check at the falling edge,
    // then advance the model flag at the rising edge.
    task automatic op(input string req, input logic [4:0] c, input logic [1:0] f,
                      input logic [15:0] a, input logic [15:0] b,
                      input logic is, input logic [4:0] im, input logic we);
        int er; bit ec;
        op_class = c; func = f; src_a = a; src_b = b;
        imm_sel = is; imm5 = im; flag_we = we;
        @(negedge clk);
        model(er, ec);
        cmp(req, "result", int'(result), er);
        cmp(req, "carry_out", int'(carry_out), int'(ec));
        cmp("R10", "zero", int'(zero), int'(er == 0));
        cmp(req, "carry_q", int'(carry_q), int'(m_flag));
        @(posedge clk);
        if (we) m_flag = ec;
        #1;
    endtask

    initial begin
        rst_n = 1'b0; op_class = '0; func = '0; imm5 = '0; imm_sel = 1'b0;
        src_a = '0; src_b = '0; flag_we = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        m_flag = 1'b0;
        cmp("R8", "reset carry_q", int'(carry_q), 0);
        rst_n = 1'b1;
        // R1 plain add, overflow and the flag ignored
        op("R1", 5'd0, 2'b00, 16'h1234, 16'h0001, 0, 0, 1);
        op("R1", 5'd0, 2'b00, 16'hFFFF, 16'h0001, 0, 0, 1);
        op("R1", 5'd0, 2'b00, 16'h0005, 16'h0006, 0, 0, 0);
        // R2 add with carry: flag set by set-carry first
        op("R8", 5'd4, 2'b00, 16'h0, 16'h0, 0, 0, 1);
        op("R2", 5'd0, 2'b01, 16'hFFFF, 16'h0000, 0, 0, 1);
        op("R2", 5'd0, 2'b01, 16'h0010, 16'h0020, 0, 0, 1);
        // R3 subtract with borrow out; flag ignored
        op("R3", 5'd0, 2'b10, 16'h0000, 16'h0001, 0, 0, 1);
        op("R3", 5'd0, 2'b10, 16'h0009, 16'h0009, 0, 0, 0);
        // R4 subtract with borrow, flag still 1
        op("R4", 5'd0, 2'b11, 16'h0009, 16'h0009, 0, 0, 1);
        op("R4", 5'd0, 2'b11, 16'h0100, 16'h0001, 0, 0, 1);
        // R5 bitwise, with flag_we high to probe R9
        op("R5", 5'd1, 2'b00, 16'hF0F0, 16'hFF00, 0, 0, 1);
        op("R5", 5'd1, 2'b01, 16'hF0F0, 16'h0F00, 0, 0, 1);
        op("R5", 5'd1, 2'b10, 16'hAAAA, 16'hFFFF, 0, 0, 1);
        op("R5", 5'd1, 2'b11, 16'h00FF, 16'h1234, 0, 0, 1);
        op("R8", 5'd4, 2'b00, 16'h0, 16'h0, 0, 0, 1);
        op("R9", 5'd1, 2'b00, 16'h0000, 16'h0000, 0, 0, 1);
        // R6 shifts with the edge bit
        op("R6", 5'd2, 2'b00, 16'h8001, 16'h0, 0, 0, 1);
        op("R6", 5'd2, 2'b01, 16'h8001, 16'h0, 0, 0, 1);
        op("R6", 5'd2, 2'b10, 16'hBEEF, 16'h0, 0, 0, 1);
        // R7 immediate add and subtract, B ignored
        op("R7", 5'd0, 2'b00, 16'h0010, 16'hFFFF, 1, 5'd31, 1);
        op("R7", 5'd0, 2'b10, 16'h0003, 16'h0000, 1, 5'd4, 1);
        // R9 flag hold with flag_we low
        op("R9", 5'd0, 2'b00, 16'hFFFF, 16'hFFFF, 0, 0, 0);
        op("R9", 5'd0, 2'b00, 16'h0000, 16'h0000, 0, 0, 1);
        // R10 unassigned classes
        op("R10", 5'd3, 2'b01, 16'h1234, 16'h5678, 0, 0, 1);
        op("R10", 5'd31, 2'b11, 16'hFFFF, 16'hFFFF, 0, 0, 1);
        // Random traffic compared every cycle
        for (int i = 0; i < 400; i++) begin
            logic [4:0] rc;
            rc = ($urandom_range(0, 9) < 6) ? 5'($urandom_range(0, 2)) : 5'($urandom_range(0, 31));
            op("R1", rc, 2'($urandom), 16'($urandom), 16'($urandom),
               1'($urandom), 5'($urandom), 1'($urandom));
        end
        // R8 reset clears a set flag
        op("R8", 5'd4, 2'b00, 16'h0, 16'h0, 0, 0, 1);
        rst_n = 1'b0;
        @(posedge clk); #1;
        cmp("R8", "carry_q after reset", int'(carry_q), 0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(TCK * 100000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule